// File: doc/BRIEF.md
# Digital Carrier Tracking Loop with Selectable Phase Detector

This block is an all-digital, first-order phase-locked loop that follows a 1-bit carrier. A phase accumulator serves as the numerically controlled oscillator (NCO), and its top bit is the recovered clock. Each clock cycle, a phase detector compares the registered carrier with the recovered clock. Over every NCO period the detector's high and low samples are tallied into a signed error word. Until the next period boundary, that word times a loop gain is added to a nominal increment. The loop filter is unity, so the control path is purely proportional.

A static select input picks the detector. The first choice is a memoryless equality gate: its output is high when both inputs match, so the error is largest when they are aligned, lowest when they are opposed, and at mid-scale in quadrature. In this mode the loop settles with the recovered clock leading the carrier by a quarter period. The second choice is an edge-driven state bit: a carrier rising edge sets it and a recovered-clock rising edge clears it. Its duty cycle is the delay from a carrier edge to the next recovered-clock edge, so the error is lowest just after alignment, highest just before it, and at mid-scale at half a period. In this mode the loop settles in phase opposition. The edge detector has half the slope of the equality gate, so it is given twice the gain. Both modes therefore have the same loop bandwidth. With the default widths this bandwidth is about 0.02 of the carrier rate for a 64-sample carrier period.

A lock flag rises after a programmable number of consecutive periods whose error magnitude stays below a threshold.

Top module: `cpll_tracker`

## Requirements
- R1: Each cycle the accumulator (ACC_W bits, zero after reset) adds the current increment modulo 2^ACC_W. `rclk` is its most significant bit. A period ends on the cycle in which `rclk` is 1 after having been 0 in the previous cycle.
- R2: With `det_sel`=0 the detector output is 1 exactly when the carrier (registered once) equals `rclk`.
- R3: With `det_sel`=1 the detector state is set by a rising edge of the registered carrier and cleared on a period end. When both fall in the same cycle, the clear wins. The detector output is the registered state.
- R4: Each cycle adds +1 (detector high) or -1 (detector low) to a running sum, which saturates at ±(2^(PER_LOG2+1)-1). At a period end, the sum including that cycle is loaded into `err_val` and the running sum restarts at 0. `err_val` is otherwise held. It reads as (high fraction - 0.5) with PER_LOG2+1 fraction bits, relative to the nominal 2^PER_LOG2-sample period.
- R5: The increment is `nom_inc` + `err_val`·2^GAIN_SH with `det_sel`=0, or `nom_inc` + `err_val`·2^(GAIN_SH+1) with `det_sel`=1. It is clamped to the range 1 to 2^ACC_W-1.
- R6: At each period end, if the new error magnitude is below `lock_thr`, a streak counter (saturating at LOCK_PERIODS) advances; otherwise it is cleared. `locked` is 1 while the streak equals LOCK_PERIODS.
- R7: With `det_sel`=0, a carrier whose period matches the nominal period is tracked to lock, with `rclk` agreeing with the registered carrier about half the time (quadrature).
- R8: With `det_sel`=1, the same carrier is tracked to lock with `rclk` almost never agreeing with the registered carrier (opposition).
- R9: While `rst_n` is low, `rclk`, `err_val` and `locked` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| carrier_in | input | 1 | Hard-limited carrier to track |
| det_sel | input | 1 | Detector choice, static: 0 equality gate, 1 edge state bit |
| nom_inc | input | ACC_W | Free-running NCO increment |
| lock_thr | input | PER_LOG2+2 | Error magnitude bound for the lock streak |
| rclk | output | 1 | Recovered clock (accumulator MSB) |
| locked | output | 1 | Lock indication |
| err_val | output | PER_LOG2+3 | Signed error of the last completed period |

## Verification
In edge-detector mode, a carrier rising edge and a period end can land in the same cycle, so one cycle asks the state bit to set and to clear. Sweeping every start phase of a carrier whose period equals the NCO period makes this collision recur. A phase jump applied after lock forces it deliberately. A cycle-level reference model in the bench predicts `rclk`, `err_val` and `locked` from the requirements, with clear taking priority. Any wrong priority shows up as a shifted error word one period later and a divergent recovered clock after that.

// File: rtl/cpll_pkg.sv
package cpll_pkg;

   typedef enum logic {
      DET_MATCH = 1'b0,
      DET_EDGE  = 1'b1
   } det_kind_e;

endpackage

// File: rtl/cpll_nco.sv
module cpll_nco
   import cpll_pkg::*;
#(
   parameter int ACC_W   = 24,
   parameter int ERR_W   = 9,
   parameter int GAIN_SH = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ACC_W-1:0]        nom_inc,
   input  logic signed [ERR_W-1:0] err_q,
   input  det_kind_e               mode,
   output logic                    rclk,
   output logic                    rclk_rise
);

   localparam int SW = ACC_W + 2;
   localparam logic signed [SW-1:0] INC_LO = SW'(1);
   localparam logic signed [SW-1:0] INC_HI = {2'b00, {ACC_W{1'b1}}};

   logic signed [SW-1:0] err_ext, corr, raw;
   logic [ACC_W-1:0]     inc, acc_q;
   logic                 rclk_p;

   // proportional path: edge detector has half the slope, so one more shift
   assign err_ext = SW'(err_q);
   assign corr    = (mode == DET_EDGE) ? (err_ext <<< (GAIN_SH + 1))
                                       : (err_ext <<< GAIN_SH);
   assign raw     = $signed({2'b00, nom_inc}) + corr;

   always_comb begin
      if (raw < INC_LO)      inc = ACC_W'(1);
      else if (raw > INC_HI) inc = {ACC_W{1'b1}};
      else                   inc = raw[ACC_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         rclk_p <= 1'b0;
      end else begin
         acc_q  <= acc_q + inc;
         rclk_p <= rclk;
      end
   end

   assign rclk      = acc_q[ACC_W-1];
   assign rclk_rise = rclk & ~rclk_p;

   // R1
   acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> acc_q == ACC_W'($past(acc_q) + $past(inc)));

   // R5
   inc_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> acc_q != $past(acc_q));

endmodule

// File: rtl/cpll_phase_det.sv
module cpll_phase_det
   import cpll_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      carrier_in,
   input  logic      rclk,
   input  logic      rclk_rise,
   input  det_kind_e mode,
   output logic      det_hi
);

   logic car_q, car_p, edge_q, car_rise;

   assign car_rise = car_q & ~car_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         car_q  <= 1'b0;
         car_p  <= 1'b0;
         edge_q <= 1'b0;
      end else begin
         car_q <= carrier_in;
         car_p <= car_q;
         // clear on the recovered edge dominates a coincident carrier edge
         if (rclk_rise)     edge_q <= 1'b0;
         else if (car_rise) edge_q <= 1'b1;
      end
   end

   generate
      always_comb begin
         if (mode == DET_EDGE) det_hi = edge_q;
         else                  det_hi = ~(car_q ^ rclk);
      end
   endgenerate

   // R3
   edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (car_rise && !rclk_rise) |=> edge_q);

   // R3
   edge_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rclk_rise |=> !edge_q);

endmodule

// File: rtl/cpll_err_avg.sv
module cpll_err_avg #(
   parameter int PER_LOG2 = 6,
   parameter int ERR_W    = PER_LOG2 + 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    det_hi,
   input  logic                    rclk_rise,
   output logic signed [ERR_W-1:0] err_next,
   output logic signed [ERR_W-1:0] err_q
);

   localparam int SAT = 2 ** (PER_LOG2 + 1) - 1;
   localparam logic signed [ERR_W-1:0] ONE   = ERR_W'(1);
   localparam logic signed [ERR_W-1:0] SAT_P = ERR_W'(SAT);
   localparam logic signed [ERR_W-1:0] SAT_N = -ERR_W'(SAT);

   logic signed [ERR_W-1:0] sum_q, stepped;

   assign stepped = det_hi ? (sum_q + ONE) : (sum_q - ONE);

   always_comb begin
      if (stepped > SAT_P)      err_next = SAT_P;
      else if (stepped < SAT_N) err_next = SAT_N;
      else                      err_next = stepped;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q <= '0;
         err_q <= '0;
      end else if (rclk_rise) begin
         sum_q <= '0;
         err_q <= err_next;
      end else begin
         sum_q <= err_next;
      end
   end

   // R4
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rclk_rise |=> $stable(err_q));

   // R4
   err_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q <= SAT_P) && (err_q >= SAT_N));

endmodule

// File: rtl/cpll_lock.sv
module cpll_lock #(
   parameter int ERR_W        = 9,
   parameter int LOCK_PERIODS = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    upd,
   input  logic signed [ERR_W-1:0] err_next,
   input  logic [ERR_W-2:0]        thr,
   output logic                    locked
);

   localparam int CNT_W = $clog2(LOCK_PERIODS + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(LOCK_PERIODS);

   logic [ERR_W-1:0] mag;
   logic [CNT_W-1:0] streak_q;
   logic             quiet;

   assign mag   = err_next[ERR_W-1] ? -err_next : err_next;
   assign quiet = mag < {1'b0, thr};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            streak_q <= '0;
      else if (upd) begin
         if (!quiet)         streak_q <= '0;
         else if (streak_q != FULL) streak_q <= streak_q + 1'b1;
      end
   end

   assign locked = (streak_q == FULL);

   // R6
   lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(upd));

   // R6
   lock_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !quiet) |=> !locked);

endmodule

// File: rtl/cpll_tracker.sv
module cpll_tracker
   import cpll_pkg::*;
#(
   parameter int ACC_W        = 24,
   parameter int PER_LOG2     = 6,
   parameter int GAIN_SH      = 6,
   parameter int LOCK_PERIODS = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       carrier_in,
   input  logic                       det_sel,
   input  logic [ACC_W-1:0]           nom_inc,
   input  logic [PER_LOG2+1:0]        lock_thr,
   output logic                       rclk,
   output logic                       locked,
   output logic signed [PER_LOG2+2:0] err_val
);

   localparam int ERR_W = PER_LOG2 + 3;

   generate
      if (PER_LOG2 < 2) begin : g_bad_per
         $error("PER_LOG2 must be at least 2");
      end
      if (ACC_W < PER_LOG2 + GAIN_SH + 6) begin : g_bad_acc
         $error("ACC_W too narrow for the shifted error");
      end
      if (LOCK_PERIODS < 1) begin : g_bad_lock
         $error("LOCK_PERIODS must be positive");
      end
   endgenerate

   det_kind_e               mode;
   logic                    rclk_rise, det_hi;
   logic signed [ERR_W-1:0] err_next, err_q;

   assign mode = det_kind_e'(det_sel);

   cpll_nco #(.ACC_W(ACC_W), .ERR_W(ERR_W), .GAIN_SH(GAIN_SH)) u_nco (
      .clk(clk), .rst_n(rst_n), .nom_inc(nom_inc), .err_q(err_q),
      .mode(mode), .rclk(rclk), .rclk_rise(rclk_rise));

   cpll_phase_det u_det (
      .clk(clk), .rst_n(rst_n), .carrier_in(carrier_in), .rclk(rclk),
      .rclk_rise(rclk_rise), .mode(mode), .det_hi(det_hi));

   cpll_err_avg #(.PER_LOG2(PER_LOG2), .ERR_W(ERR_W)) u_avg (
      .clk(clk), .rst_n(rst_n), .det_hi(det_hi), .rclk_rise(rclk_rise),
      .err_next(err_next), .err_q(err_q));

   cpll_lock #(.ERR_W(ERR_W), .LOCK_PERIODS(LOCK_PERIODS)) u_lock (
      .clk(clk), .rst_n(rst_n), .upd(rclk_rise), .err_next(err_next),
      .thr(lock_thr), .locked(locked));

   assign err_val = err_q;

   // R9
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> (!rclk && !locked && err_val == 0));

endmodule

// File: tb/sim_cpll_tracker.sv
module sim_cpll_tracker;

   localparam int CLK_PERIOD = 10;
   localparam int AW   = 12;
   localparam int PL   = 3;
   localparam int GS   = 1;
   localparam int LP   = 4;
   localparam int EW   = PL + 3;
   localparam int SAT  = 2 ** (PL + 1) - 1;
   localparam int MAXI = 2 ** AW - 1;

   logic clk = 1'b0, rst_n = 1'b0, carrier_in = 1'b0, det_sel = 1'b0;
   logic [AW-1:0]        nom_inc  = AW'(512);
   logic [PL+1:0]        lock_thr = 3;
   logic                 rclk, locked;
   logic signed [EW-1:0] err_val;

   always #(CLK_PERIOD / 2) clk = ~clk;

   cpll_tracker #(.ACC_W(AW), .PER_LOG2(PL), .GAIN_SH(GS), .LOCK_PERIODS(LP)) u0 (
      .clk(clk), .rst_n(rst_n), .carrier_in(carrier_in), .det_sel(det_sel),
      .nom_inc(nom_inc), .lock_thr(lock_thr), .rclk(rclk), .locked(locked),
      .err_val(err_val));

   int n_chk = 0, n_fail = 0, cyc = 0;
   int cp = 8, cph = 0, car_const = -1;
   bit agree;

   // reference model state, built from the requirements
   int m_acc, m_rp, m_cq, m_cp, m_ff, m_sum, m_err, m_str;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_acc = 0; m_rp = 0; m_cq = 0; m_cp = 0;
         m_ff = 0; m_sum = 0; m_err = 0; m_str = 0;
      end else begin
         int r, rise, crise, det, es, sh, inc, mag;
         r     = (m_acc >> (AW - 1)) & 1;
         rise  = (r == 1 && m_rp == 0);
         crise = (m_cq == 1 && m_cp == 0);
         det   = det_sel ? m_ff : ((m_cq == r) ? 1 : 0);
         es    = m_sum + (det ? 1 : -1);
         if (es > SAT) es = SAT;
         if (es < -SAT) es = -SAT;
         sh  = det_sel ? GS + 1 : GS;
         inc = int'(nom_inc) + m_err * (1 << sh);
         if (inc < 1) inc = 1;
         if (inc > MAXI) inc = MAXI;
         m_acc = (m_acc + inc) % (MAXI + 1);
         m_rp  = r;
         m_cp  = m_cq;
         m_cq  = int'(carrier_in);
         if (rise) m_ff = 0;
         else if (crise) m_ff = 1;
         if (rise) begin
            m_err = es;
            m_sum = 0;
            mag = (es < 0) ? -es : es;
            if (mag < int'(lock_thr)) m_str = (m_str < LP) ? m_str + 1 : LP;
            else m_str = 0;
         end else begin
            m_sum = es;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_fail++;
         $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 150000);
         summary();
         $finish;
      end
   end

   function automatic logic car_level();
      if (car_const >= 0) return car_const[0];
      return (cph < cp / 2);
   endfunction

   task automatic step();
      int er, el;
      @(negedge clk);
      er = (m_acc >> (AW - 1)) & 1;
      el = (m_str == LP) ? 1 : 0;
      check(int'(rclk) == er, "R1 R5 recovered clock", int'(rclk), er);
      check(int'(err_val) == m_err, "R2 R3 R4 error word", int'(err_val), m_err);
      check(int'(locked) == el, "R6 lock flag", int'(locked), el);
      agree = (rclk == carrier_in);
      cph = (cph + 1) % cp;
      carrier_in = car_level();
   endtask

   task automatic do_reset(input int ph);
      rst_n = 1'b0;
      cph = ph;
      carrier_in = car_level();
      repeat (2) @(negedge clk);
      check(rclk == 1'b0, "R9 rclk in reset", int'(rclk), 0);
      check(err_val == 0, "R9 error in reset", int'(err_val), 0);
      check(locked == 1'b0, "R9 lock in reset", int'(locked), 0);
      rst_n = 1'b1;
   endtask

   task automatic run_case(input bit sel, input int nom, input int per, input int ph, input int n);
      det_sel = sel;
      nom_inc = AW'(nom);
      cp = per;
      car_const = -1;
      do_reset(ph);
      repeat (n) step();
   endtask

   initial begin
      int cnt, seen, hi_steps;
      bit prev;

      // sweep both detectors, three carrier periods, every start phase
      for (int s = 0; s < 2; s++)
         for (int pi = 0; pi < 3; pi++)
            for (int ph = 0; ph < 7 + pi; ph++)
               run_case(s[0], (pi == 2) ? 455 : 512, 7 + pi, ph, 300);

      // R7: equality detector pulls into quadrature and locks
      run_case(1'b0, 512, 8, 3, 1500);
      check(locked == 1'b1, "R7 lock reached", int'(locked), 1);
      cnt = 0;
      for (int i = 0; i < 64; i++) begin
         step();
         cnt += int'(agree);
      end
      check(cnt >= 16 && cnt <= 48, "R7 quadrature agreement", cnt, 32);

      // R8: edge detector pulls into opposition and locks
      run_case(1'b1, 512, 8, 3, 1500);
      check(locked == 1'b1, "R8 lock reached", int'(locked), 1);
      cnt = 0;
      for (int i = 0; i < 64; i++) begin
         step();
         cnt += int'(agree);
      end
      check(cnt <= 16, "R8 opposition agreement", cnt, 0);

      // R6: a phase jump breaks the streak at the next period end
      cph = (cph + 4) % cp;
      seen = 0;
      for (int i = 0; i < 24; i++) begin
         step();
         if (!locked) seen = 1;
      end
      check(seen == 1, "R6 lock lost after jump", seen, 1);

      // R4 saturation and R5 increment floor: edge mode, carrier stuck low
      det_sel = 1'b1;
      nom_inc = AW'(32);
      cp = 8;
      car_const = 0;
      do_reset(0);
      for (int i = 0; i < 200; i++) begin
         prev = rclk;
         step();
         if (!prev && rclk) break;
      end
      step();
      check(int'(err_val) == -SAT, "R4 saturated error", int'(err_val), -SAT);
      hi_steps = 0;
      while (rclk && hi_steps < 2500) begin
         step();
         hi_steps++;
      end
      check(hi_steps >= 1000 && hi_steps < 2100, "R5 increment floor of one", hi_steps, 1984);

      summary();
      $finish;
   end

endmodule